// File: doc/BRIEF.md
# Keyed Watchdog Reset Unit

This block is a watchdog timer that requests a system reset when software stops servicing it. It has a 64-bit up-counter and a 64-bit period, and each of them is exposed as two 32-bit halves. A small register port controls the unit: one global-control word selects the watchdog timer mode and releases the two counter halves, and one watchdog-control word carries a sticky enable bit and a 16-bit key field. Software sets the mode, clears the counter, loads a period and then arms the unit. Arming takes two key writes in a fixed order. After arming, software must repeat the same two keys before the counter reaches the period.

The key sequencer has five named states. IDLE is the state after reset. PREARM means the first key has been seen. ACTIVE means the unit is counting. SERVICE means the first key has been seen again while counting. TRIPPED means a reset has been requested. The transitions are:
- arm-step (IDLE to PREARM): first key written with the enable bit set.
- go (PREARM to ACTIVE): second key written.
- abort (PREARM to IDLE): any other key written.
- service-step (ACTIVE to SERVICE): first key written.
- kick (SERVICE to ACTIVE): second key written; this clears the counter.
- trip (ACTIVE or SERVICE to TRIPPED): the period is reached, or a wrong key is written.

TRIPPED is left only through `rst_n`. While the unit is in ACTIVE, SERVICE or TRIPPED, the counter, period and global-control registers are locked.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n`, `rst_req` is low and every register reads as zero.
- R2: The register offsets are 0 counter-low, 1 counter-high, 2 period-low, 3 period-high, 4 global-control and 5 watchdog-control. A read returns data on `rdata` in the cycle after `rd_en`. Watchdog-control reads show the enable bit at bit 14 and zero everywhere else, including the key field at bits 31:16.
- R3: Once the enable bit has been written as 1, it stays 1 until `rst_n`, whatever is written later.
- R4: The go transition clears the counter to zero. `rst_req` rises P+1 cycles after the go write, where P is the period, and stays high for exactly one cycle.
- R5: The unit runs only when global-control bits 3:2 hold 2 and bits 1:0 are both 1. Otherwise key writes do not leave IDLE and the counter holds its value.
- R6: A write to watchdog-control in IDLE or PREARM that is not the expected step returns the unit to IDLE and never raises `rst_req`.
- R7: In ACTIVE, any key other than 0xA5C6 raises `rst_req` in the cycle after the write. In SERVICE, any key other than 0xDA7E does the same.
- R8: In ACTIVE, writing 0xA5C6 and then 0xDA7E clears the counter, so the P+1 timeout restarts from the second write.
- R9: In ACTIVE, SERVICE and TRIPPED, writes to the counter, period and global-control registers are ignored.
- R10: In TRIPPED, no further `rst_req` is raised and key writes have no effect until `rst_n`.
- R11: The first key is 0xA5C6 and must be written with bit 14 set. The second key is 0xDA7E. Both are written in bits 31:16 of watchdog-control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Each result has a fixed latency in cycles:
- Register read data is valid one cycle after the read strobe.
- A wrong-key reset request is visible one cycle after its write.
- A timeout request appears P+1 cycles after the last second-key write.

Stimulus is driven on falling edges and outputs are sampled on the next falling edge, so every result is counted in whole cycles from the write that causes it. Random service gaps are bounded to P-3 idle cycles so that a correct unit cannot time out between kicks. The expected timeout is compared to an exact cycle count, not a window.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PREARM  = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_SERVICE = 3'd3,
        ST_TRIPPED = 3'd4
    } wd_state_e;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PRD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_PRD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_GCTL   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_WCTL   = 3'd5;

endpackage

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int HALF_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  clr,
    input  logic [1:0]            ld,
    input  logic [HALF_W-1:0]     ld_data,
    input  logic [2*HALF_W-1:0]   prd,
    output logic [2*HALF_W-1:0]   cnt,
    output logic                  hit
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_prd;

    assign at_prd  = (cnt == prd);
    assign hit     = run && at_prd;
    assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_nxt = cnt;
        if (clr) begin
            cnt_nxt = '0;
        end else if (run && !at_prd) begin
            cnt_nxt = cnt_inc;
        end
        for (int h = 0; h < 2; h++) begin
            if (ld[h]) begin
                cnt_nxt[h*HALF_W +: HALF_W] = ld_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ld == 2'b00) |=> (cnt == '0));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr && ld == 2'b00) |=> $stable(cnt));

endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          EN_BIT    = 14,
    parameter logic [1:0]  MODE_WDOG = 2'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 locked,
    input  logic [2*DATA_W-1:0]  cnt,
    output logic [2*DATA_W-1:0]  prd,
    output logic [1:0]           cnt_ld,
    output logic                 wctl_wr,
    output logic                 run_ok,
    output logic                 wden,
    output logic [DATA_W-1:0]    rdata
);
    localparam int GCTL_W = 4;

    logic [GCTL_W-1:0] gctl;
    logic [1:0]        prd_ld;
    logic              gctl_wr;
    logic [DATA_W-1:0] rd_mux;

    assign wctl_wr = wr_en && (addr == OFS_WCTL);
    assign gctl_wr = wr_en && (addr == OFS_GCTL) && !locked;
    assign cnt_ld[0] = wr_en && (addr == OFS_CNT_LO) && !locked;
    assign cnt_ld[1] = wr_en && (addr == OFS_CNT_HI) && !locked;
    assign prd_ld[0] = wr_en && (addr == OFS_PRD_LO) && !locked;
    assign prd_ld[1] = wr_en && (addr == OFS_PRD_HI) && !locked;

    assign run_ok = (gctl[3:2] == MODE_WDOG) && (gctl[1:0] == 2'b11);

    generate
        for (genvar g = 0; g < 2; g++) begin : g_prd_half
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prd[g*DATA_W +: DATA_W] <= '0;
                end else if (prd_ld[g]) begin
                    prd[g*DATA_W +: DATA_W] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gctl <= '0;
        end else if (gctl_wr) begin
            gctl <= wdata[GCTL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wden <= 1'b0;
        end else if (wctl_wr && wdata[EN_BIT]) begin
            wden <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            OFS_CNT_LO: rd_mux = cnt[DATA_W-1:0];
            OFS_CNT_HI: rd_mux = cnt[2*DATA_W-1:DATA_W];
            OFS_PRD_LO: rd_mux = prd[DATA_W-1:0];
            OFS_PRD_HI: rd_mux = prd[2*DATA_W-1:DATA_W];
            OFS_GCTL:   rd_mux[GCTL_W-1:0] = gctl;
            OFS_WCTL:   rd_mux[EN_BIT] = wden;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    // R3
    wden_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wden |=> wden);

    // R9
    prd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(prd));

    // R9
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(run_ok));

endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
#(
    parameter int           KEY_W   = 16,
    parameter logic [15:0]  KEY_ARM = 16'hA5C6,
    parameter logic [15:0]  KEY_GO  = 16'hDA7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wctl_wr,
    input  logic [KEY_W-1:0]  key,
    input  logic              en_bit,
    input  logic              run_ok,
    input  logic              hit,
    output logic              run,
    output logic              svc_clr,
    output logic              locked,
    output logic              rst_req
);
    wd_state_e st, st_nxt;
    logic      trip;

    always_comb begin
        st_nxt  = st;
        trip    = 1'b0;
        svc_clr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (wctl_wr && run_ok && en_bit && key == KEY_ARM[KEY_W-1:0]) begin
                    st_nxt = ST_PREARM;
                end
            end
            ST_PREARM: begin
                if (wctl_wr) begin
                    if (run_ok && key == KEY_GO[KEY_W-1:0]) begin
                        st_nxt  = ST_ACTIVE;
                        svc_clr = 1'b1;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
            end
            ST_ACTIVE: begin
                if (hit) begin
                    trip = 1'b1;
                end else if (wctl_wr) begin
                    if (key == KEY_ARM[KEY_W-1:0]) begin
                        st_nxt = ST_SERVICE;
                    end else begin
                        trip = 1'b1;
                    end
                end
            end
            ST_SERVICE: begin
                if (hit) begin
                    trip = 1'b1;
                end else if (wctl_wr) begin
                    if (key == KEY_GO[KEY_W-1:0]) begin
                        st_nxt  = ST_ACTIVE;
                        svc_clr = 1'b1;
                    end else begin
                        trip = 1'b1;
                    end
                end
            end
            ST_TRIPPED: begin
                st_nxt = ST_TRIPPED;
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
        if (trip) begin
            st_nxt = ST_TRIPPED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= trip;
        end
    end

    assign locked = (st == ST_ACTIVE) || (st == ST_SERVICE) || (st == ST_TRIPPED);
    assign run    = ((st == ST_ACTIVE) || (st == ST_SERVICE)) && run_ok;

    // R4
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ACTIVE || st == ST_SERVICE) && hit) |=> (rst_req && st == ST_TRIPPED));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_PREARM) |=> !rst_req);

    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && wctl_wr && key != KEY_ARM[KEY_W-1:0]) |=> rst_req);

    // R10
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRIPPED) |=> (st == ST_TRIPPED && !rst_req));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int           DATA_W    = 32,
    parameter int           EN_BIT    = 14,
    parameter int           KEY_LSB   = 16,
    parameter int           KEY_W     = 16,
    parameter logic [15:0]  KEY_ARM   = 16'hA5C6,
    parameter logic [15:0]  KEY_GO    = 16'hDA7E,
    parameter logic [1:0]   MODE_WDOG = 2'd2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rst_req
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] prd;
    logic [1:0]       cnt_ld;
    logic             wctl_wr;
    logic             run_ok;
    logic             wden;
    logic             run;
    logic             svc_clr;
    logic             locked;
    logic             hit;

    wdk_regs #(
        .DATA_W    (DATA_W),
        .EN_BIT    (EN_BIT),
        .MODE_WDOG (MODE_WDOG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .locked  (locked),
        .cnt     (cnt),
        .prd     (prd),
        .cnt_ld  (cnt_ld),
        .wctl_wr (wctl_wr),
        .run_ok  (run_ok),
        .wden    (wden),
        .rdata   (rdata)
    );

    wdk_fsm #(
        .KEY_W   (KEY_W),
        .KEY_ARM (KEY_ARM),
        .KEY_GO  (KEY_GO)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wctl_wr (wctl_wr),
        .key     (wdata[KEY_LSB +: KEY_W]),
        .en_bit  (wdata[EN_BIT]),
        .run_ok  (run_ok),
        .hit     (hit),
        .run     (run),
        .svc_clr (svc_clr),
        .locked  (locked),
        .rst_req (rst_req)
    );

    wdk_counter #(
        .HALF_W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (svc_clr),
        .ld      (cnt_ld),
        .ld_data (wdata),
        .prd     (prd),
        .cnt     (cnt),
        .hit     (hit)
    );

    // R3
    wden_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> wden);

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    keyed_wdt u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rst_req (rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [31:0] W_ARM  = 32'hA5C6_4000;
    localparam logic [31:0] W_GO   = 32'hDA7E_4000;
    localparam logic [31:0] G_WDOG = 32'h0000_000B;

    function automatic int exp_timeout(input int p);
        return p + 1;
    endfunction

    function automatic logic [31:0] exp_wctl(input bit en);
        return en ? 32'h0000_4000 : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic quiet(input int k, output int seen);
        seen = 0;
        for (int i = 0; i < k; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req) seen++;
        end
    endtask

    task automatic until_req(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic setup(input int p);
        wr(3'd4, G_WDOG);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, p);
        wr(3'd3, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        int n, s, p;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 rst_req", rst_req, 0);
        rd(3'd5, d); chk("R1 wctl", d, 0);
        rd(3'd4, d); chk("R1 gctl", d, 0);
        rd(3'd2, d); chk("R1 prd_lo", d, 0);

        // R2 register access
        p = 12;
        setup(p);
        rd(3'd2, d); chk("R2 prd_lo", d, p);
        rd(3'd4, d); chk("R2 gctl", d, G_WDOG);
        wr(3'd0, 32'h1234); wr(3'd1, 32'h55);
        rd(3'd0, d); chk("R2 cnt_lo", d, 32'h1234);
        rd(3'd1, d); chk("R2 cnt_hi", d, 32'h55);
        wr(3'd0, 0); wr(3'd1, 0);

        // R2/R6 enable with wrong key in IDLE, key field reads zero
        wr(3'd5, 32'h0000_4000);
        chk("R6 no req", rst_req, 0);
        rd(3'd5, d); chk("R2 wctl read", d, exp_wctl(1));
        // R3 enable sticky
        wr(3'd5, 32'hFFFF_BFFF);
        rd(3'd5, d); chk("R3 sticky", d, exp_wctl(1));

        // R5 wrong mode: keys do not arm
        wr(3'd4, 32'h7);
        wr(3'd5, W_ARM); wr(3'd5, W_GO);
        quiet(p + 8, s); chk("R5 no req", s, 0);
        rd(3'd0, d); chk("R5 cnt held", d, 0);
        wr(3'd4, G_WDOG);

        // R6 wrong key in PREARM returns to IDLE
        wr(3'd5, W_ARM); wr(3'd5, 32'h1234_4000); wr(3'd5, W_GO);
        quiet(p + 8, s); chk("R6 abort no req", s, 0);
        rd(3'd0, d); chk("R6 cnt idle", d, 0);

        // R4 / R11 arm and time out
        wr(3'd5, W_ARM); wr(3'd5, W_GO);
        until_req(p + 20, n); chk("R4 timeout", n, exp_timeout(p));
        @(posedge clk); @(negedge clk);
        chk("R4 one cycle", rst_req, 0);
        // R10 tripped stays quiet
        wr(3'd5, W_ARM); wr(3'd5, 32'h0);
        quiet(20, s); chk("R10 quiet", s, 0);
        // R9 locks
        wr(3'd2, 32'd99); rd(3'd2, d); chk("R9 prd lock", d, p);
        wr(3'd4, 32'h0);  rd(3'd4, d); chk("R9 gctl lock", d, G_WDOG);

        // R7 wrong key in ACTIVE
        do_reset(); setup(30);
        wr(3'd5, W_ARM); wr(3'd5, W_GO);
        quiet(2, s);
        wr(3'd5, 32'h0000_4000);
        chk("R7 active bad key", rst_req, 1);
        @(posedge clk); @(negedge clk);
        chk("R7 pulse end", rst_req, 0);

        // R7 wrong second key in SERVICE
        do_reset(); setup(30);
        wr(3'd5, W_ARM); wr(3'd5, W_GO);
        wr(3'd5, W_ARM); wr(3'd5, 32'hBEEF_4000);
        chk("R7 service bad key", rst_req, 1);
        // R9 counter lock: write ignored while tripped
        wr(3'd0, 32'h77); rd(3'd0, d);
        chk("R9 cnt lock", (d == 32'h77), 0);

        // R8 random service rounds
        for (int r = 0; r < 10; r++) begin
            int nsvc, w;
            do_reset();
            p = 4 + int'($urandom % 28);
            setup(p);
            wr(3'd5, W_ARM); wr(3'd5, W_GO);
            nsvc = int'($urandom % 4);
            for (int k = 0; k < nsvc; k++) begin
                w = int'($urandom % (p - 2));
                quiet(w, s); chk("R8 no early req", s, 0);
                wr(3'd5, W_ARM); wr(3'd5, W_GO);
            end
            until_req(p + 20, n);
            chk(nsvc > 0 ? "R8 kick timeout" : "R4 timeout rnd", n, exp_timeout(p));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule